// File: doc/BRIEF.md
# ATAPI PIO Packet Transfer Sequencer

This block is the device end of an ATA task-file register set, reduced to a single job. It runs the PACKET command with PIO data-in transfers of a READ(10) request. A host programs byte-wide task registers through a small register port and moves 16-bit words through a separate data port. After the packet command is issued, the block takes a 12-byte command packet and decodes the start block and block count from it. It then tells a media source where to begin and passes words from that source to the host.

The data phase is split into bursts. The host sets a byte-count limit before the command, and the block forces that limit to an even value. Each burst is at most that many bytes, and the last burst carries whatever is left. Before every burst the block raises an interrupt and shows the data-request status. The host reads status, which drops the interrupt, reads back the burst size and then drains the words. One more interrupt marks the end of the command. A bad request is aborted with an error status and an interrupt. A bad request is a zero usable limit, the DMA feature bit, a command other than PACKET, or an unsupported packet opcode.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status byte (offset 7) reads 0x40 and the error byte (offset 1) reads 0x00. The interrupt is low.
- R2: Register offsets are 1 features on write and error on read, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, and 7 command on write and status on read. Offsets 2 to 6 read back what was written. A write to offset 1 does not change what offset 1 reads. Status bits are BSY 0x80, DRDY 0x40, DRQ 0x08 and ERR 0x01.
- R3: Writing 0xA0 to offset 7 while idle starts a command, provided feature bit 0 is clear and the usable limit is nonzero. Status then reads 0xC0 for BSY_CYCLES cycles and then 0x48, with no interrupt. The block then waits for six data-port writes.
- R4: Each packet word carries packet byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Byte 0 is the opcode (0x28). Bytes 2 to 5 are a big-endian start block and bytes 7 to 8 a big-endian block count. Both appear on the media outputs with one media_start pulse.
- R5: The usable limit is {offset 5, offset 4} with bit 0 cleared. Each burst is min(limit, bytes left) bytes, and a block is 2048 bytes.
- R6: Before each burst the interrupt rises with status 0x48. Offsets 4 (low) and 5 (high) then read the burst byte count.
- R7: Reading status clears the interrupt.
- R8: After the last word of the last burst the interrupt rises and status reads 0x40.
- R9: While the media source has no word for the start of a burst, status reads 0xC0 and the interrupt stays low.
- R10: Words reach the host in the order the media source supplies them, with none lost or repeated.
- R11: The command is aborted when the usable limit is zero, feature bit 0 is set, the command byte is not 0xA0, or the opcode is not 0x28. An abort sets the error byte to 0x04, status to 0x41 and raises the interrupt. The next accepted command clears ERR.
- R12: A READ(10) with a block count of zero completes at once with the interrupt and status 0x40, and sends no media_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Task register write strobe |
| reg_rd | input | 1 | Task register read strobe (status read clears interrupt) |
| reg_addr | input | 3 | Task register offset |
| reg_wdata | input | 8 | Task register write byte |
| reg_rdata | output | 8 | Task register read byte |
| data_wr | input | 1 | Data port write strobe (packet words) |
| data_rd | input | 1 | Data port read strobe (consumes one word) |
| data_wdata | input | 16 | Data port write word |
| data_rdata | output | 16 | Data port read word |
| irq | output | 1 | Interrupt request |
| media_start | output | 1 | One-cycle pulse that starts the media stream |
| media_lba | output | 32 | Decoded start block |
| media_blocks | output | 16 | Decoded block count |
| media_valid | input | 1 | Media word available |
| media_ready | output | 1 | Media word accepted when valid |
| media_word | input | 16 | Media data word |

## Verification
The hardest state to reach is the turn from one burst to the next. The media source must still be short of a word at the very start of a burst, while the host has already drained the previous one. The bench holds media_valid low across packet decode. It observes the busy status and the silent interrupt, then releases the stream. A limit of 2 bytes forces over a thousand back-to-back burst turns, and odd limits and a limit equal to one block cover rounding and the exact-boundary last burst.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;

    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_DRDY = 8'h40;
    localparam logic [7:0] ST_DRQ  = 8'h08;
    localparam logic [7:0] ST_ERR  = 8'h01;
    localparam logic [7:0] ERR_ABORTED = 8'h04;

    localparam logic [7:0] CMD_PACKET = 8'hA0;
    localparam logic [7:0] OPC_READ10 = 8'h28;

    localparam logic [2:0] OFS_ERRFEAT = 3'd1;
    localparam logic [2:0] OFS_SECCNT  = 3'd2;
    localparam logic [2:0] OFS_LBALO   = 3'd3;
    localparam logic [2:0] OFS_LBAMID  = 3'd4;
    localparam logic [2:0] OFS_LBAHI   = 3'd5;
    localparam logic [2:0] OFS_DEVSEL  = 3'd6;
    localparam logic [2:0] OFS_STATCMD = 3'd7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMDBSY,
        PH_PKT,
        PH_DECODE,
        PH_FETCH,
        PH_XFER
    } phase_e;

endpackage

// File: rtl/pkt_collector.sv
module pkt_collector #(
    parameter int PKT_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic        last,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] blocks
);
    localparam int CNT_W = $clog2(PKT_WORDS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       opc;
        logic [31:0]      lba;
        logic [15:0]      blk;
    } col_t;

    col_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (wr && q.cnt < CNT_W'(PKT_WORDS)) begin
            d.cnt = q.cnt + CNT_W'(1);
            if (q.cnt == CNT_W'(0)) begin
                d.opc = wdata[7:0];
            end else if (q.cnt == CNT_W'(1)) begin
                d.lba[31:24] = wdata[7:0];
                d.lba[23:16] = wdata[15:8];
            end else if (q.cnt == CNT_W'(2)) begin
                d.lba[15:8] = wdata[7:0];
                d.lba[7:0]  = wdata[15:8];
            end else if (q.cnt == CNT_W'(3)) begin
                d.blk[15:8] = wdata[15:8];
            end else if (q.cnt == CNT_W'(4)) begin
                d.blk[7:0] = wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign last   = wr && (q.cnt == CNT_W'(PKT_WORDS - 1));
    assign opcode = q.opc;
    assign lba    = q.lba;
    assign blocks = q.blk;

    // R4: the word counter never runs past the packet length
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(PKT_WORDS))
        else $error("packet word counter overran");

endmodule

// File: rtl/burst_sizer.sv
module burst_sizer #(
    parameter int LIM_W = 15,
    parameter int REM_W = 27
) (
    input  logic [LIM_W-1:0] half_limit,
    input  logic [REM_W-1:0] remaining,
    output logic [LIM_W-1:0] words
);
    always_comb begin
        if (REM_W'(half_limit) < remaining) words = half_limit;
        else                                words = remaining[LIM_W-1:0];
    end
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
    import atapi_seq_pkg::*;
#(
    parameter int BSY_CYCLES  = 4,
    parameter int BLOCK_WORDS = 1024,
    parameter int PKT_WORDS   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        data_wr,
    input  logic        data_rd,
    input  logic [15:0] data_wdata,
    output logic [15:0] data_rdata,
    output logic        irq,
    output logic        media_start,
    output logic [31:0] media_lba,
    output logic [15:0] media_blocks,
    input  logic        media_valid,
    output logic        media_ready,
    input  logic [15:0] media_word
);
    localparam int BCL_W = 16;
    localparam int LIM_W = BCL_W - 1;
    localparam int BLK_W = 16;
    localparam int REM_W = BLK_W + $clog2(BLOCK_WORDS) + 1;
    localparam int BSY_W = $clog2(BSY_CYCLES + 1);

    typedef struct packed {
        phase_e           ph;
        logic [BSY_W-1:0] bsy_cnt;
        logic             feat_dma;
        logic [7:0]       err;
        logic [7:0]       seccnt;
        logic [7:0]       lba_lo;
        logic [7:0]       lba_mid;
        logic [7:0]       lba_hi;
        logic [7:0]       dev;
        logic             irq;
        logic [LIM_W-1:0] half_lim;
        logic [REM_W-1:0] rem;
        logic [LIM_W-1:0] burst_left;
        logic [15:0]      hold;
        logic             hold_ok;
    } ctl_t;

    ctl_t q, d;

    logic             pkt_clear;
    logic             pkt_wr;
    logic             pkt_last;
    logic [7:0]       pkt_opc;
    logic [31:0]      pkt_lba;
    logic [15:0]      pkt_blk;
    logic [LIM_W-1:0] sz_words;
    logic [7:0]       status_b;
    logic [BCL_W-1:0] host_limit;
    logic             cmd_write;
    logic             stat_read;

    assign pkt_wr     = data_wr && (q.ph == PH_PKT);
    assign host_limit = {q.lba_hi, q.lba_mid};
    assign cmd_write  = reg_wr && (reg_addr == OFS_STATCMD);
    assign stat_read  = reg_rd && (reg_addr == OFS_STATCMD);

    pkt_collector #(.PKT_WORDS(PKT_WORDS)) u_pkt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pkt_clear),
        .wr     (pkt_wr),
        .wdata  (data_wdata),
        .last   (pkt_last),
        .opcode (pkt_opc),
        .lba    (pkt_lba),
        .blocks (pkt_blk)
    );

    burst_sizer #(.LIM_W(LIM_W), .REM_W(REM_W)) u_size (
        .half_limit (q.half_lim),
        .remaining  (q.rem),
        .words      (sz_words)
    );

    always_comb begin
        d         = q;
        pkt_clear = 1'b0;

        if (stat_read) d.irq = 1'b0;

        if (reg_wr) begin
            case (reg_addr)
                OFS_ERRFEAT: d.feat_dma = reg_wdata[0];
                OFS_SECCNT:  d.seccnt   = reg_wdata;
                OFS_LBALO:   d.lba_lo   = reg_wdata;
                OFS_LBAMID:  d.lba_mid  = reg_wdata;
                OFS_LBAHI:   d.lba_hi   = reg_wdata;
                OFS_DEVSEL:  d.dev      = reg_wdata;
                default: ;
            endcase
        end

        case (q.ph)
            PH_IDLE: begin
                if (cmd_write) begin
                    d.err = 8'h00;
                    if (reg_wdata != CMD_PACKET || q.feat_dma ||
                        host_limit[BCL_W-1:1] == '0) begin
                        d.err = ERR_ABORTED;
                        d.irq = 1'b1;
                    end else begin
                        d.ph       = PH_CMDBSY;
                        d.bsy_cnt  = '0;
                        d.half_lim = host_limit[BCL_W-1:1];
                        pkt_clear  = 1'b1;
                    end
                end
            end
            PH_CMDBSY: begin
                if (q.bsy_cnt == BSY_W'(BSY_CYCLES - 1)) d.ph = PH_PKT;
                else d.bsy_cnt = q.bsy_cnt + BSY_W'(1);
            end
            PH_PKT: begin
                if (pkt_last) d.ph = PH_DECODE;
            end
            PH_DECODE: begin
                if (pkt_opc != OPC_READ10) begin
                    d.err = ERR_ABORTED;
                    d.irq = 1'b1;
                    d.ph  = PH_IDLE;
                end else if (pkt_blk == '0) begin
                    d.irq = 1'b1;
                    d.ph  = PH_IDLE;
                end else begin
                    d.rem     = REM_W'(pkt_blk) * REM_W'(BLOCK_WORDS);
                    d.hold_ok = 1'b0;
                    d.ph      = PH_FETCH;
                end
            end
            PH_FETCH: begin
                if (media_valid) begin
                    d.hold       = media_word;
                    d.hold_ok    = 1'b1;
                    d.burst_left = sz_words;
                    {d.lba_hi, d.lba_mid} = {sz_words, 1'b0};
                    d.irq        = 1'b1;
                    d.ph         = PH_XFER;
                end
            end
            PH_XFER: begin
                if (!q.hold_ok && media_valid) begin
                    d.hold    = media_word;
                    d.hold_ok = 1'b1;
                end
                if (data_rd && q.hold_ok) begin
                    d.rem        = q.rem - REM_W'(1);
                    d.burst_left = q.burst_left - LIM_W'(1);
                    d.hold_ok    = 1'b0;
                    if (q.burst_left == LIM_W'(1)) begin
                        if (q.rem == REM_W'(1)) begin
                            d.irq = 1'b1;
                            d.ph  = PH_IDLE;
                        end else begin
                            d.ph = PH_FETCH;
                        end
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.ph)
            PH_IDLE:        status_b = ST_DRDY | ((q.err != 8'h00) ? ST_ERR : 8'h00);
            PH_PKT, PH_XFER: status_b = ST_DRQ | ST_DRDY;
            default:        status_b = ST_BSY | ST_DRDY;
        endcase
    end

    always_comb begin
        case (reg_addr)
            OFS_ERRFEAT: reg_rdata = q.err;
            OFS_SECCNT:  reg_rdata = q.seccnt;
            OFS_LBALO:   reg_rdata = q.lba_lo;
            OFS_LBAMID:  reg_rdata = q.lba_mid;
            OFS_LBAHI:   reg_rdata = q.lba_hi;
            OFS_DEVSEL:  reg_rdata = q.dev;
            OFS_STATCMD: reg_rdata = status_b;
            default:     reg_rdata = 8'h00;
        endcase
    end

    assign data_rdata   = (q.ph == PH_XFER) ? q.hold : 16'h0000;
    assign irq          = q.irq;
    assign media_ready  = (q.ph == PH_FETCH) || (q.ph == PH_XFER && !q.hold_ok);
    assign media_start  = (q.ph == PH_DECODE) && (pkt_opc == OPC_READ10) && (pkt_blk != '0);
    assign media_lba    = pkt_lba;
    assign media_blocks = pkt_blk;

    // R7: a status read during a burst leaves the interrupt low
    a_r7_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && q.ph == PH_XFER && !data_rd) |=> !irq)
        else $error("status read did not clear interrupt");

    // R9: a starved burst start stays in the fetch phase
    a_r9_hold_while_starved: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_FETCH && !media_valid) |=> (q.ph == PH_FETCH))
        else $error("burst started without media word");

    // R5: a burst never exceeds the even limit or the words left
    a_r5_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_XFER) |-> (q.burst_left != '0 && q.burst_left <= q.half_lim &&
                               REM_W'(q.burst_left) <= q.rem))
        else $error("burst size out of bounds");

    // R11: ERR in status always comes with the abort code
    a_r11_err_has_abort: assert property (@(posedge clk) disable iff (!rst_n)
        status_b[0] |-> (q.err == ERR_ABORTED))
        else $error("ERR without abort code");

    // R4: a media start is followed by the fetch phase
    a_r4_start_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        media_start |=> (q.ph == PH_FETCH))
        else $error("media start without fetch");

    // R8: consuming the final word ends the command with an interrupt
    a_r8_final_word_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_XFER && data_rd && q.hold_ok && q.rem == REM_W'(1))
        |=> (irq && q.ph == PH_IDLE))
        else $error("no completion interrupt");

    // R3: BSY and DRQ are never shown together
    a_r3_bsy_drq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_b[7] && status_b[3]))
        else $error("BSY with DRQ");

endmodule

// File: tb/tb_atapi_pio_seq.sv
module tb_atapi_pio_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        data_wr = 1'b0, data_rd = 1'b0;
    logic [15:0] data_wdata = 16'h0000;
    logic [15:0] data_rdata;
    logic        irq;
    logic        media_start;
    logic [31:0] media_lba;
    logic [15:0] media_blocks;
    logic        media_valid;
    logic        media_ready;
    logic [15:0] media_word;

    logic        mv = 1'b1;
    logic [31:0] widx = 32'd0;
    int          n_start = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    atapi_pio_seq dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_wr(data_wr), .data_rd(data_rd),
        .data_wdata(data_wdata), .data_rdata(data_rdata),
        .irq(irq),
        .media_start(media_start), .media_lba(media_lba), .media_blocks(media_blocks),
        .media_valid(media_valid), .media_ready(media_ready), .media_word(media_word)
    );

    // media model: word k of block b is ((b*1024 + k) low 16 bits) ^ 0x5A3C
    assign media_valid = mv;
    assign media_word  = widx[15:0] ^ 16'h5A3C;

    always @(posedge clk) begin
        if (media_start) begin
            widx    <= media_lba * 32'd1024;
            n_start <= n_start + 1;
        end else if (media_valid && media_ready) begin
            widx <= widx + 32'd1;
        end
    end

    // {limit, start block, block count}
    localparam logic [63:0] VECS [6] = '{
        {16'd5120, 32'h0000_0000, 16'd1},
        {16'd5121, 32'h0000_0003, 16'd3},
        {16'd1000, 32'h0001_2345, 16'd1},
        {16'hFFFF, 32'h0000_0007, 16'd2},
        {16'd2,    32'h0000_0040, 16'd1},
        {16'd2048, 32'h00AB_CDEF, 16'd2}
    };

    function automatic logic [15:0] exp_word(input logic [31:0] lba, input int k);
        logic [31:0] t;
        t = lba * 32'd1024 + 32'(k);
        return t[15:0] ^ 16'h5A3C;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_data(input logic [15:0] v);
        @(negedge clk);
        data_wdata = v; data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic rd_data(output logic [15:0] v);
        @(negedge clk);
        data_rd = 1'b1;
        #1 v = data_rdata;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (irq) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic send_pkt(input logic [7:0] opc, input logic [31:0] lba, input logic [15:0] blk);
        wr_data({8'h00, opc});
        wr_data({lba[23:16], lba[31:24]});
        wr_data({lba[7:0], lba[15:8]});
        wr_data({blk[15:8], 8'h00});
        wr_data({8'h00, blk[7:0]});
        wr_data(16'h0000);
    endtask

    task automatic start_cmd(input logic [15:0] limit);
        logic [7:0] s;
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd4, limit[7:0]);
        wr_reg(3'd5, limit[15:8]);
        wr_reg(3'd7, 8'hA0);
        rd_reg(3'd7, s);
        check("R3 busy right after command", s, 8'hC0);
        for (int i = 0; i < 20 && s[7]; i++) rd_reg(3'd7, s);
        check("R3 packet phase status", s, 8'h48);
        check("R3 no interrupt in packet phase", irq, 1'b0);
    endtask

    task automatic expect_abort(input string tag);
        bit ok;
        logic [7:0] v;
        wait_irq(ok);
        check({tag, " R11 abort interrupt"}, ok, 1'b1);
        rd_reg(3'd1, v);
        check({tag, " R11 error byte"}, v, 8'h04);
        rd_reg(3'd7, v);
        check({tag, " R11 status byte"}, v, 8'h41);
        check({tag, " R7 interrupt cleared"}, irq, 1'b0);
    endtask

    task automatic run_read10(input logic [15:0] limit, input logic [31:0] lba,
                              input logic [15:0] blk, input bit starve);
        logic [7:0]  s, lo, hi;
        logic [15:0] w;
        int rem, bw, lim_e, k, bad, st0;
        bit ok;
        start_cmd(limit);
        st0 = n_start;
        if (starve) mv = 1'b0;
        send_pkt(8'h28, lba, blk);
        repeat (3) @(negedge clk);
        check("R4 decoded start block", media_lba, lba);
        check("R4 decoded block count", {16'h0, media_blocks}, {16'h0, blk});
        check("R4 single media start", n_start - st0, 1);
        if (starve) begin
            repeat (20) @(negedge clk);
            check("R9 no interrupt while starved", irq, 1'b0);
            rd_reg(3'd7, s);
            check("R9 busy while starved", s, 8'hC0);
            mv = 1'b1;
        end
        lim_e = int'(limit) & 32'hFFFE;
        rem   = int'(blk) * 2048;
        k     = 0;
        while (rem > 0) begin
            bw = (lim_e < rem) ? lim_e : rem;
            wait_irq(ok);
            check("R6 interrupt before burst", ok, 1'b1);
            rd_reg(3'd7, s);
            check("R6 burst status", s, 8'h48);
            check("R7 status read clears interrupt", irq, 1'b0);
            rd_reg(3'd4, lo);
            rd_reg(3'd5, hi);
            check("R5 burst byte count", {16'h0, hi, lo}, bw);
            bad = 0;
            for (int j = 0; j < bw / 2; j++) begin
                rd_data(w);
                if (w !== exp_word(lba, k)) bad++;
                k++;
            end
            check("R10 burst words in media order", bad, 0);
            rem -= bw;
        end
        wait_irq(ok);
        check("R8 completion interrupt", ok, 1'b1);
        rd_reg(3'd7, s);
        check("R8 final status", s, 8'h40);
        check("R7 completion interrupt cleared", irq, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit ok;
        int st0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd7, v);
        check("R1 reset status", v, 8'h40);
        rd_reg(3'd1, v);
        check("R1 reset error", v, 8'h00);
        check("R1 reset interrupt", irq, 1'b0);

        // R2 register map
        wr_reg(3'd2, 8'h5A);
        wr_reg(3'd3, 8'h11);
        wr_reg(3'd6, 8'hA0);
        wr_reg(3'd1, 8'hFE);
        rd_reg(3'd2, v); check("R2 sector count readback", v, 8'h5A);
        rd_reg(3'd3, v); check("R2 lba low readback", v, 8'h11);
        rd_reg(3'd6, v); check("R2 device readback", v, 8'hA0);
        rd_reg(3'd1, v); check("R2 offset 1 reads error not features", v, 8'h00);
        wr_reg(3'd1, 8'h00);

        // main table
        for (int i = 0; i < 6; i++)
            run_read10(VECS[i][63:48], VECS[i][47:16], VECS[i][15:0], 1'b0);

        // R11 aborts
        wr_reg(3'd4, 8'h00); wr_reg(3'd5, 8'h00); wr_reg(3'd7, 8'hA0);
        expect_abort("zero limit");
        wr_reg(3'd4, 8'h01); wr_reg(3'd5, 8'h00); wr_reg(3'd7, 8'hA0);
        expect_abort("limit one");
        wr_reg(3'd4, 8'h00); wr_reg(3'd5, 8'h02); wr_reg(3'd1, 8'h01); wr_reg(3'd7, 8'hA0);
        expect_abort("dma feature");
        wr_reg(3'd1, 8'h00); wr_reg(3'd7, 8'hEC);
        expect_abort("other command");
        start_cmd(16'd512);
        send_pkt(8'h12, 32'd0, 16'd1);
        expect_abort("bad opcode");

        // R12 zero block count
        start_cmd(16'd512);
        st0 = n_start;
        send_pkt(8'h28, 32'd9, 16'd0);
        wait_irq(ok);
        check("R12 zero count interrupt", ok, 1'b1);
        rd_reg(3'd7, v);
        check("R12 zero count status", v, 8'h40);
        check("R12 no media start", n_start - st0, 0);

        // R9 starved media at burst start
        run_read10(16'd1024, 32'd5, 16'd1, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule